// File: doc/BRIEF.md
# Differential Successive Approximation Sequencer

This block is the digital half of a converter that measures the difference between a positive analog input and a negative analog input. It steps through two sampling phases and then a binary search that starts at the most significant bit. In each step it drives a trial code to an external resistor-string DAC and comparator. It reads back one compare bit per step, and at the end it latches the final code and pulses a completion flag. The analog side is outside the block. A sibling model, or the testbench, turns the trial code and the two inputs into the compare bit.

The sequencer advances only on cycles where the internal conversion clock enable is high. A start request is accepted at once when the engine is idle. While the negative input is being sampled, the trial code is zero. The compare bit taken on that phase therefore reports the polarity of the difference. When that bit shows the positive input is not above the negative input, the whole conversion is forced to zero. The timing of the conversion does not change.

Top module: `sardiff_sar`

## Requirements
- R1: After synchronous reset, busy, done, samp_pos and samp_neg are 0, and trial_code and result are 0x00.
- R2: A start pulse seen in idle is accepted on that clock edge whatever clk_en is, and busy is 1 in the following cycle.
- R3: After acceptance, samp_pos is high until the first enabled edge. samp_neg is then high until the second enabled edge. trial_code is 0x00 during both phases.
- R4: Bits are resolved MSB first. The first trial code is 0x80, and each later trial keeps the decided upper bits and sets the next lower bit.
- R5: On an enabled trial edge the bit under test is kept when cmp_hi is 1 and cleared when it is 0. With an ideal comparator (cmp_hi = difference ≥ trial code) the result equals the difference for differences 0 to 255.
- R6: If cmp_hi is 0 at the enabled edge that ends the negative sample phase, the result is 0x00 whatever cmp_hi does during the trials.
- R7: done is high for exactly one clock. result takes its new value on the same edge that raises done, busy is 0 in that cycle, and result holds until the next transfer.
- R8: A start pulse while busy has no effect on the sequence, the timing or the result.
- R9: The engine holds its state on cycles with clk_en low. From acceptance to done takes exactly WIDTH+3 enabled edges (11 for 8 bits), which is 12 clocks with clk_en held high.
- R10: A difference above full scale saturates to 0xFF, and a negative difference gives 0x00.
- R11: A start in the same cycle that done is high is accepted and begins a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Internal conversion clock enable |
| start | input | 1 | Start request pulse |
| cmp_hi | input | 1 | Comparator: difference ≥ trial code |
| trial_code | output | WIDTH | Code driven to the DAC |
| samp_pos | output | 1 | Positive input sampling phase |
| samp_neg | output | 1 | Negative input sampling phase |
| busy | output | 1 | Conversion in progress |
| result | output | WIDTH | Last completed conversion code |
| done | output | 1 | One-clock completion pulse |

## Verification
The completion pulse of one conversion and the acceptance of the next start can fall in the same cycle. The transfer edge returns the engine to idle while done is raised. The bench provokes this by driving start high in the very cycle it sees done. It then judges that busy rises on the next clock, that the first result stays intact, and that the second conversion yields its own difference. A start during a running conversion is also injected, and the bench confirms that the sequence timing and the result stay unchanged.

// File: rtl/sardiff_pkg.sv
`timescale 1ns/1ps
package sardiff_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_SAMP_P = 3'd1,
        PH_SAMP_N = 3'd2,
        PH_TRIAL  = 3'd3,
        PH_XFER   = 3'd4
    } sar_phase_e;
endpackage

// File: rtl/sardiff_ctrl.sv
`timescale 1ns/1ps
module sardiff_ctrl
    import sardiff_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en,
    input  logic          start,
    output logic          accept,
    output logic          samp_pos,
    output logic          samp_neg,
    output logic          busy,
    output logic          load_first,
    output logic          trial_en,
    output logic          last_bit,
    output logic          xfer,
    output logic [IW-1:0] bit_idx
);
    typedef struct packed {
        sar_phase_e    ph;
        logic [IW-1:0] idx;
    } ctrl_t;

    ctrl_t c_q, c_d;

    always_comb begin
        c_d = c_q;
        case (c_q.ph)
            PH_IDLE:   if (start) c_d.ph = PH_SAMP_P;
            PH_SAMP_P: if (clk_en) c_d.ph = PH_SAMP_N;
            PH_SAMP_N: if (clk_en) begin
                c_d.ph  = PH_TRIAL;
                c_d.idx = IW'(WIDTH - 1);
            end
            PH_TRIAL:  if (clk_en) begin
                if (c_q.idx == '0) c_d.ph = PH_XFER;
                else               c_d.idx = c_q.idx - 1'b1;
            end
            PH_XFER:   if (clk_en) c_d.ph = PH_IDLE;
            default:   c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.ph  <= PH_IDLE;
            c_q.idx <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign accept     = (c_q.ph == PH_IDLE) && start;
    assign samp_pos   = (c_q.ph == PH_SAMP_P);
    assign samp_neg   = (c_q.ph == PH_SAMP_N);
    assign busy       = (c_q.ph != PH_IDLE);
    assign load_first = samp_neg && clk_en;
    assign trial_en   = (c_q.ph == PH_TRIAL) && clk_en;
    assign last_bit   = (c_q.idx == '0);
    assign xfer       = (c_q.ph == PH_XFER) && clk_en;
    assign bit_idx    = c_q.idx;

    // R3
    phase_order_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.ph == PH_SAMP_P && clk_en) |=> (c_q.ph == PH_SAMP_N));
    // R9
    gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !clk_en) |=> ($stable(c_q.ph) && $stable(c_q.idx)));
    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (c_q.ph == PH_TRIAL && start) |=> (c_q.ph != PH_SAMP_P));
endmodule

// File: rtl/sardiff_code_reg.sv
`timescale 1ns/1ps
module sardiff_code_reg #(
    parameter int WIDTH = 8,
    localparam int IW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             load_first,
    input  logic             trial_en,
    input  logic             last_bit,
    input  logic [IW-1:0]    bit_idx,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] code
);
    typedef struct packed {
        logic [WIDTH-1:0] code;
        logic             clamp;
    } creg_t;

    creg_t r_q, r_d;
    logic [WIDTH-1:0] mask;
    logic [WIDTH-1:0] decided;

    always_comb begin
        r_d     = r_q;
        mask    = WIDTH'(1) << bit_idx;
        decided = (cmp_hi && !r_q.clamp) ? r_q.code : (r_q.code & ~mask);
        if (accept) begin
            r_d.code  = '0;
            r_d.clamp = 1'b0;
        end else if (load_first) begin
            r_d.clamp = !cmp_hi;
            r_d.code  = {1'b1, {(WIDTH-1){1'b0}}};
        end else if (trial_en) begin
            r_d.code = last_bit ? decided : (decided | (mask >> 1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q.code  <= '0;
            r_q.clamp <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign code = r_q.code;

    // R6
    clamp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (r_q.clamp && trial_en && last_bit) |=> (r_q.code == '0));
    // R4
    msb_first_chk: assert property (@(posedge clk) disable iff (rst)
        load_first |=> ($onehot(r_q.code) && r_q.code[WIDTH-1]));
endmodule

// File: rtl/sardiff_out_latch.sv
`timescale 1ns/1ps
module sardiff_out_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             xfer,
    input  logic [WIDTH-1:0] code,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             done;
    } oreg_t;

    oreg_t o_q, o_d;

    always_comb begin
        o_d      = o_q;
        o_d.done = xfer;
        if (xfer) o_d.result = code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q.result <= '0;
            o_q.done   <= 1'b0;
        end else begin
            o_q <= o_d;
        end
    end

    assign result = o_q.result;
    assign done   = o_q.done;

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        o_q.done |=> !o_q.done);
    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(o_q.result));
endmodule

// File: rtl/sardiff_sar.sv
`timescale 1ns/1ps
module sardiff_sar #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clk_en,
    input  logic             start,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial_code,
    output logic             samp_pos,
    output logic             samp_neg,
    output logic             busy,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    localparam int IW = $clog2(WIDTH);

    logic          accept, load_first, trial_en, last_bit, xfer;
    logic [IW-1:0] bit_idx;

    sardiff_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk(clk), .rst(rst), .clk_en(clk_en), .start(start),
        .accept(accept), .samp_pos(samp_pos), .samp_neg(samp_neg),
        .busy(busy), .load_first(load_first), .trial_en(trial_en),
        .last_bit(last_bit), .xfer(xfer), .bit_idx(bit_idx)
    );

    sardiff_code_reg #(.WIDTH(WIDTH)) u_code (
        .clk(clk), .rst(rst), .accept(accept), .load_first(load_first),
        .trial_en(trial_en), .last_bit(last_bit), .bit_idx(bit_idx),
        .cmp_hi(cmp_hi), .code(trial_code)
    );

    sardiff_out_latch #(.WIDTH(WIDTH)) u_out (
        .clk(clk), .rst(rst), .xfer(xfer), .code(trial_code),
        .result(result), .done(done)
    );

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy || samp_pos);
endmodule

// File: tb/sardiff_sar_bench.sv
`timescale 1ns/1ps
module sardiff_sar_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       clk_en;
    logic       cmp_hi;
    logic [7:0] trial_code, result;
    logic       samp_pos, samp_neg, busy, done;

    int diff = 0;
    int force_mode = 0;
    int en_div = 1;
    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;
    assign clk_en = (en_div <= 1) || ((cyc % en_div) == 0);
    assign cmp_hi = (force_mode == 1) ? !samp_neg :
                    (force_mode == 2) ? 1'b1 :
                    (diff >= int'(trial_code));

    sardiff_sar #(.WIDTH(8)) u_sardiff_sar (
        .clk(clk), .rst(rst), .clk_en(clk_en), .start(start), .cmp_hi(cmp_hi),
        .trial_code(trial_code), .samp_pos(samp_pos), .samp_neg(samp_neg),
        .busy(busy), .result(result), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic int ideal(input int d);
        if (d <= 0) return 0;
        if (d > 255) return 255;
        return d;
    endfunction

    // Starts a conversion, optionally injects a start at a given cycle while busy,
    // and checks result, latency, enabled-edge count and done width.
    task automatic run_conv(input int d, input int fm, input int dup_at,
                            input int exp_res, input int exp_clks, input string req);
        int clks = 0;
        int ens  = 0;
        diff = d;
        force_mode = fm;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        clks = 1;
        while (!done && clks < 400) begin
            ens += int'(clk_en);
            if (clks == dup_at) start = 1'b1;
            step();
            start = 1'b0;
            clks++;
        end
        check({req, " result"}, int'(result), exp_res);
        if (exp_clks > 0) check({req, " R9 latency"}, clks, exp_clks);
        check({req, " R9 enabled edges"}, ens, 11);
        check({req, " R7 busy low at done"}, int'(busy), 0);
        step();
        check({req, " R7 done one clock"}, int'(done), 0);
        check({req, " R7 result held"}, int'(result), exp_res);
        force_mode = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);
        check("R1 trial_code", int'(trial_code), 0);
        check("R1 phases", int'(samp_pos) + int'(samp_neg), 0);
    endtask

    task automatic t_phases();
        en_div = 1;
        diff = 90;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        check("R2 busy after accept", int'(busy), 1);
        check("R3 samp_pos first", int'(samp_pos), 1);
        check("R3 code zero in sampling", int'(trial_code), 0);
        step();
        check("R3 samp_neg second", int'(samp_neg), 1);
        check("R3 samp_pos low", int'(samp_pos), 0);
        step();
        check("R4 first trial 0x80", int'(trial_code), 128);
        step();
        check("R4 second trial 0x40", int'(trial_code), 64);
        step();
        check("R4 third trial 0x60", int'(trial_code), 96);
        for (int i = 0; i < 12 && !done; i++) step();
        check("R5 result 90", int'(result), 90);
        step();
    endtask

    task automatic t_values();
        en_div = 1;
        run_conv(0,   0, -1, 0,   12, "R5 zero");
        run_conv(1,   0, -1, 1,   12, "R5 one");
        run_conv(255, 0, -1, 255, 12, "R5 full");
        run_conv(170, 0, -1, 170, 12, "R5 alt 0xAA");
        run_conv(85,  0, -1, 85,  12, "R5 alt 0x55");
        run_conv(400, 0, -1, 255, 12, "R10 saturate");
        run_conv(-30, 0, -1, 0,   12, "R10 negative");
    endtask

    task automatic t_clamp();
        en_div = 1;
        run_conv(200, 1, -1, 0,   12, "R6 clamp forces zero");
        run_conv(200, 2, -1, 255, 12, "R6 no clamp all keep");
    endtask

    task automatic t_busy_start();
        en_div = 1;
        run_conv(77, 0, 5, 77, 12, "R8 start while busy");
        run_conv(33, 0, 2, 33, 12, "R8 start in sampling");
    endtask

    task automatic t_gated();
        en_div = 3;
        run_conv(123, 0, -1, 123, -1, "R9 gated enable");
        en_div = 1;
    endtask

    task automatic t_back_to_back();
        int clks = 0;
        en_div = 1;
        diff = 60;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        while (!done && clks < 40) begin
            step();
            clks++;
        end
        check("R11 first result", int'(result), 60);
        diff = 201;
        start = 1'b1;
        step();
        start = 1'b0;
        check("R11 busy after start at done", int'(busy), 1);
        check("R11 first result kept", int'(result), 60);
        clks = 0;
        while (!done && clks < 40) begin
            step();
            clks++;
        end
        check("R11 second result", int'(result), 201);
        check("R11 second latency", clks + 1, 12);
        step();
    endtask

    task automatic t_reset_mid();
        en_div = 1;
        diff = 150;
        step();
        start = 1'b1;
        step();
        start = 1'b0;
        step(); step(); step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R1 reset mid busy", int'(busy), 0);
        check("R1 reset mid result", int'(result), 0);
        check("R1 reset mid code", int'(trial_code), 0);
    endtask

    initial begin
        t_reset();
        t_phases();
        t_values();
        t_clamp();
        t_busy_start();
        t_gated();
        t_back_to_back();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule